// File: doc/BRIEF.md
# Adjacent-State Minimum-Cost Path Array

This block finds the cheapest path through a trellis of `NS` states by `NCOL` columns. The path may move by at most one state per column. It is a linear array of identical processing elements, one per state, all stepping in lock step. In the forward phase, each column strobe makes every element do two things. It takes the registered costs of itself and its two adjacent elements, adds a per-direction transition cost to each, keeps the cheapest and adds its own local cost. It also pushes a two-bit relative parent pointer onto a stack that belongs to that element alone.

In the backward phase, the state with the lowest final cost receives a single on-path flag. Each cycle, every element pops its stack. The element holding the flag hands it to the neighbour its popped pointer names. A controller adds the same popped pointers to a running row index and emits one row per stored column, starting with the last column. No central traceback memory is used: the path is recovered from neighbour-to-neighbour flag hand-offs.

The host pulses `start_fwd`, presents one column of costs with each `col_valid`, then pulses `start_bwd` and collects `path_row` while `path_valid` is high.

Top module: `viterbi_path_array`

## Requirements
- R1: After reset, `path_valid` is low, no columns are stored and the array is idle; `col_valid` is ignored until a `start_fwd` is accepted.
- R2: An accepted `start_fwd` sets every element's accumulated cost to zero, empties every stack and clears every on-path flag. A later backward pass then yields only the columns pushed after it.
- R3: On each accepted column, element j computes its new cost as min over candidates (previous cost of the source element plus that candidate's transition cost) plus the local cost of j. The local cost of j is `local_cost[j*CW +: CW]`. The transition cost for slot s of element j is `trans_cost[(3*j+s)*CW +: CW]`, where slot 0 is from j itself, slot 1 from j-1 and slot 2 from j+1. The result saturates at 2^CW-1.
- R4: The candidates are examined in the order self, j-1, j+1. A later candidate replaces the current best only if its value plus `EPS` is strictly below the best, so near-ties resolve to self and then to j-1.
- R5: Element 0 has no j-1 candidate and element NS-1 has no j+1 candidate; the path never leaves the state range.
- R6: Each accepted column pushes exactly one pointer per element. At most `NCOL` columns are stored, and `col_valid` pulses beyond that, or outside the forward phase, have no effect.
- R7: An accepted `start_bwd` places the flag in exactly one element: the one with the lowest final cost, with the lowest index winning on equal cost.
- R8: After `start_bwd` is accepted, `path_valid` is high on the following consecutive cycles, once per stored column. Column rows are given last column first, beginning on the clock edge after acceptance. Each next row is the previous row plus the popped pointer of that row's element (pointer code 00 stays, 01 means row-1, 10 means row+1).
- R9: Consecutive emitted rows differ by at most one.
- R10: `start_bwd` with no stored columns produces no output. While a backward pass runs, `start_fwd`, `start_bwd` and `col_valid` are ignored and the emitted rows are unchanged.
- R11: When `start_fwd` and `start_bwd` arrive together, `start_fwd` wins and the stored columns are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_fwd | input | 1 | Begin a new forward phase |
| start_bwd | input | 1 | Begin backtracking of the stored columns |
| col_valid | input | 1 | One column of costs is presented this cycle |
| local_cost | input | NS*CW | Local cost per element |
| trans_cost | input | 3*NS*CW | Transition cost per element and source slot |
| path_row | output | $clog2(NS) | Row of the path for the emitted column |
| path_valid | output | 1 | `path_row` is valid this cycle |

## Verification
The hardest situations to reach from the ports are margin decisions: a neighbour cheaper than self by exactly `EPS` versus `EPS+1`, an edge element whose own transition is expensive, and costs that hit the saturation ceiling. The bench reaches them by choosing first-column local costs that set the registered costs to chosen values, then a second column whose transition costs expose the margin. It also runs a bench-side reference trellis over pseudo-random columns. Overfilled stacks and control pulses injected mid-backtrack are checked through the count and order of emitted rows.

// File: rtl/vpa_pkg.sv
// Shared types for the adjacent-state path array.
// Assumes: pointer codes are fixed; the controller relies on them.
package vpa_pkg;
    // Relative parent pointer stored on each element's stack.
    typedef enum logic [1:0] {
        PTR_SELF = 2'b00,
        PTR_UP   = 2'b01,
        PTR_DOWN = 2'b10
    } ptr_t;

    // Controller phase.
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_FWD  = 2'b01,
        PH_BWD  = 2'b10
    } phase_t;
endpackage

// File: rtl/vpa_stack.sv
// Private pointer stack of one element.
// Assumes: the controller never pushes a full stack or pops an empty one;
// DEPTH >= 2. Contents are not reset, only the fill level.
module vpa_stack #(
    parameter int W     = 2,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [CNTW-1:0] fill;
    logic [CNTW-1:0] fill_m1;

    assign fill_m1 = fill - 1'b1;
    assign top     = (fill == '0) ? '0 : mem[fill_m1[AW-1:0]];

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push && fill < CNTW'(DEPTH)) mem[fill[AW-1:0]] <= din;
    end

    // Fill level tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                  fill <= '0;
        else if (push && fill < CNTW'(DEPTH)) fill <= fill + 1'b1;
        else if (pop && fill != '0)           fill <= fill_m1;
    end
endmodule

// File: rtl/vpa_pe.sv
// One trellis-state element: add-compare-select over self and the two
// adjacent states, a registered cost, an on-path flag and a private stack.
// Assumes: neighbour costs come from neighbour registers (lock step);
// HAS_UP/HAS_DN are 0 at the array edges so missing neighbours never win.
module vpa_pe #(
    parameter int CW     = 10,
    parameter int EPS    = 2,
    parameter int DEPTH  = 8,
    parameter bit HAS_UP = 1'b1,
    parameter bit HAS_DN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          pop,
    input  logic          load_flag,
    input  logic          flag_init,
    input  logic          flag_rx,
    input  logic [CW-1:0] cost_up,
    input  logic [CW-1:0] cost_dn,
    input  logic [CW-1:0] local_c,
    input  logic [CW-1:0] tr_self,
    input  logic [CW-1:0] tr_up,
    input  logic [CW-1:0] tr_dn,
    output logic [CW-1:0] cost,
    output logic          flag,
    output vpa_pkg::ptr_t popped
);
    import vpa_pkg::*;

    localparam int            SW   = CW + 2;
    localparam logic [CW-1:0] CMAX = '1;
    localparam logic [SW-1:0] EPSW = SW'(EPS);

    logic [SW-1:0] c_self, c_up, c_dn, best, total;
    ptr_t          sel;
    logic [CW-1:0] next_cost;
    logic [1:0]    top_raw;

    // Candidate sums and ordered selection with tolerance.
    always_comb begin
        c_self = SW'(cost) + SW'(tr_self);
        c_up   = SW'(cost_up) + SW'(tr_up);
        c_dn   = SW'(cost_dn) + SW'(tr_dn);
        best   = c_self;
        sel    = PTR_SELF;
        if (HAS_UP && (c_up + EPSW < best)) begin
            best = c_up;
            sel  = PTR_UP;
        end
        if (HAS_DN && (c_dn + EPSW < best)) begin
            best = c_dn;
            sel  = PTR_DOWN;
        end
        total     = best + SW'(local_c);
        next_cost = (total > SW'(CMAX)) ? CMAX : total[CW-1:0];
    end

    // Accumulated cost register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cost <= '0;
        else if (step)       cost <= next_cost;
    end

    // On-path flag: loaded at backtrack start, then handed between neighbours.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) flag <= 1'b0;
        else if (load_flag)  flag <= flag_init;
        else if (pop)        flag <= (flag && popped == PTR_SELF) || flag_rx;
    end

    vpa_stack #(.W(2), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .push  (step),
        .pop   (pop),
        .din   (sel),
        .top   (top_raw)
    );

    assign popped = ptr_t'(top_raw);
endmodule

// File: rtl/vpa_ctrl.sv
// Phase control, column counting and absolute row accumulation.
// Assumes: start_fwd has priority; control pulses are ignored while
// backtracking; the row follows the popped pointer of its own element.
module vpa_ctrl #(
    parameter int NS    = 4,
    parameter int DEPTH = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_fwd,
    input  logic                    start_bwd,
    input  logic                    col_valid,
    input  logic [$clog2(NS)-1:0]   best_idx,
    input  logic [2*NS-1:0]         ptr_vec,
    output logic                    clear,
    output logic                    step,
    output logic                    pop,
    output logic                    load_flag,
    output logic                    in_bwd,
    output logic [$clog2(DEPTH+1)-1:0] col_cnt,
    output logic [$clog2(NS)-1:0]   path_row,
    output logic                    path_valid
);
    import vpa_pkg::*;

    localparam int RW   = $clog2(NS);
    localparam int CNTW = $clog2(DEPTH + 1);

    phase_t          phase;
    logic [CNTW-1:0] left;
    logic [RW-1:0]   row;
    logic            acc_fwd, acc_bwd;
    ptr_t            row_ptr;

    // Acceptance and per-cycle strobes.
    always_comb begin
        acc_fwd   = start_fwd && phase != PH_BWD;
        acc_bwd   = start_bwd && !start_fwd && phase != PH_BWD;
        clear     = acc_fwd;
        step      = phase == PH_FWD && col_valid && col_cnt < CNTW'(DEPTH)
                    && !acc_fwd && !acc_bwd;
        load_flag = acc_bwd && col_cnt != '0;
        pop       = phase == PH_BWD && left != '0;
        in_bwd    = phase == PH_BWD;
        row_ptr   = ptr_t'(ptr_vec[row*2 +: 2]);
    end

    // Phase, counters and accumulated row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            col_cnt    <= '0;
            left       <= '0;
            row        <= '0;
            path_row   <= '0;
            path_valid <= 1'b0;
        end else begin
            path_valid <= 1'b0;
            if (acc_fwd) begin
                phase   <= PH_FWD;
                col_cnt <= '0;
            end else if (acc_bwd) begin
                phase <= (col_cnt == '0) ? PH_IDLE : PH_BWD;
                left  <= col_cnt;
                row   <= best_idx;
            end else if (step) begin
                col_cnt <= col_cnt + 1'b1;
            end else if (pop) begin
                path_row   <= row;
                path_valid <= 1'b1;
                left       <= left - 1'b1;
                case (row_ptr)
                    PTR_UP:   row <= row - 1'b1;
                    PTR_DOWN: row <= row + 1'b1;
                    default:  row <= row;
                endcase
                if (left == CNTW'(1)) begin
                    phase   <= PH_IDLE;
                    col_cnt <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/viterbi_path_array.sv
// Top: NS lock-step elements in a line, final-cost argmin and control.
// Assumes: NS >= 2, NCOL >= 2, EPS < 2^CW.
module viterbi_path_array #(
    parameter int NS   = 4,
    parameter int NCOL = 8,
    parameter int CW   = 10,
    parameter int EPS  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_fwd,
    input  logic                  start_bwd,
    input  logic                  col_valid,
    input  logic [NS*CW-1:0]      local_cost,
    input  logic [3*NS*CW-1:0]    trans_cost,
    output logic [$clog2(NS)-1:0] path_row,
    output logic                  path_valid
);
    import vpa_pkg::*;

    localparam int RW   = $clog2(NS);
    localparam int CNTW = $clog2(NCOL + 1);

    logic [CW-1:0]   cost_a [NS];
    logic [NS-1:0]   flag_vec;
    logic [NS-1:0]   flag_rx;
    logic [2*NS-1:0] ptr_vec;
    logic [RW-1:0]   best_idx;
    logic            clear, step, pop, load_flag, in_bwd;
    logic [CNTW-1:0] col_cnt;

    // Lowest final cost, lowest index on equal cost.
    always_comb begin
        logic [CW-1:0] bc;
        bc       = cost_a[0];
        best_idx = '0;
        for (int k = 1; k < NS; k++) begin
            if (cost_a[k] < bc) begin
                bc       = cost_a[k];
                best_idx = RW'(k);
            end
        end
    end

    for (genvar j = 0; j < NS; j++) begin : g_pe
        localparam bit HU = (j > 0);
        localparam bit HD = (j < NS - 1);
        logic [CW-1:0] c_up, c_dn;
        ptr_t          pp;
        logic          rx_a, rx_b;

        // Neighbour cost wiring and flag hand-off into element j.
        if (HU) begin : g_u
            assign c_up = cost_a[j-1];
            assign rx_a = flag_vec[j-1] && ptr_vec[2*(j-1) +: 2] == PTR_DOWN;
        end else begin : g_nu
            assign c_up = '0;
            assign rx_a = 1'b0;
        end
        if (HD) begin : g_d
            assign c_dn = cost_a[j+1];
            assign rx_b = flag_vec[j+1] && ptr_vec[2*(j+1) +: 2] == PTR_UP;
        end else begin : g_nd
            assign c_dn = '0;
            assign rx_b = 1'b0;
        end
        assign flag_rx[j]          = rx_a || rx_b;
        assign ptr_vec[2*j +: 2]   = pp;

        vpa_pe #(
            .CW(CW), .EPS(EPS), .DEPTH(NCOL), .HAS_UP(HU), .HAS_DN(HD)
        ) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (clear),
            .step      (step),
            .pop       (pop),
            .load_flag (load_flag),
            .flag_init (best_idx == RW'(j)),
            .flag_rx   (flag_rx[j]),
            .cost_up   (c_up),
            .cost_dn   (c_dn),
            .local_c   (local_cost[j*CW +: CW]),
            .tr_self   (trans_cost[(3*j)*CW +: CW]),
            .tr_up     (trans_cost[(3*j+1)*CW +: CW]),
            .tr_dn     (trans_cost[(3*j+2)*CW +: CW]),
            .cost      (cost_a[j]),
            .flag      (flag_vec[j]),
            .popped    (pp)
        );
    end

    vpa_ctrl #(.NS(NS), .DEPTH(NCOL)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_fwd  (start_fwd),
        .start_bwd  (start_bwd),
        .col_valid  (col_valid),
        .best_idx   (best_idx),
        .ptr_vec    (ptr_vec),
        .clear      (clear),
        .step       (step),
        .pop        (pop),
        .load_flag  (load_flag),
        .in_bwd     (in_bwd),
        .col_cnt    (col_cnt),
        .path_row   (path_row),
        .path_valid (path_valid)
    );
endmodule

// File: rtl/vpa_checker.sv
// Temporal checks on the path array, attached by bind.
// Assumes: flag_vec, in_bwd and col_cnt are the top's internal nets.
module vpa_checker #(
    parameter int NS    = 4,
    parameter int NCOL  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NS-1:0]              flag_vec,
    input logic                       in_bwd,
    input logic [$clog2(NCOL+1)-1:0]  col_cnt,
    input logic [$clog2(NS)-1:0]      path_row,
    input logic                       path_valid
);
    logic [NS-1:0]         prev_flag;
    logic [$clog2(NS)-1:0] prev_row;
    logic                  prev_valid;
    int                    delta;

    // History of flags and emitted rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_flag  <= '0;
            prev_row   <= '0;
            prev_valid <= 1'b0;
        end else begin
            prev_flag  <= flag_vec;
            prev_row   <= path_row;
            prev_valid <= path_valid;
        end
    end

    assign delta = int'(path_row) - int'(prev_row);

    a_r7_flag_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_vec));

    a_r8_row_holds_flag: assert property (@(posedge clk) disable iff (!rst_n)
        path_valid |-> prev_flag[path_row]);

    a_r9_adjacent_rows: assert property (@(posedge clk) disable iff (!rst_n)
        (path_valid && prev_valid) |-> (delta >= -1 && delta <= 1));

    a_r10_valid_in_bwd: assert property (@(posedge clk) disable iff (!rst_n)
        path_valid |-> $past(in_bwd));

    a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        col_cnt <= ($clog2(NCOL+1))'(NCOL));
endmodule

bind viterbi_path_array vpa_checker #(.NS(NS), .NCOL(NCOL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_vec   (flag_vec),
    .in_bwd     (in_bwd),
    .col_cnt    (col_cnt),
    .path_row   (path_row),
    .path_valid (path_valid)
);

// File: tb/sim_viterbi_path_array.sv
// Directed bench with a reference trellis built from the requirements.
module sim_viterbi_path_array;
    localparam int PERIOD = 10;
    localparam int NS     = 4;
    localparam int NCOL   = 8;
    localparam int CW     = 10;
    localparam int EPS    = 2;
    localparam int CMAX   = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_fwd = 1'b0, start_bwd = 1'b0, col_valid = 1'b0;
    logic [NS*CW-1:0]   local_cost = '0;
    logic [3*NS*CW-1:0] trans_cost = '0;
    logic [$clog2(NS)-1:0] path_row;
    logic path_valid;

    int errors = 0;
    int checks = 0;

    // Reference state.
    int m_cost [NS];
    int m_ptr  [NCOL][NS];
    int m_cols;
    bit m_fwd;
    int loc [NS];
    int tr  [NS][3];
    int exp_rows [NCOL];
    int exp_n;
    logic [31:0] lfsr = 32'h1234_5678;

    always #(PERIOD/2) clk = ~clk;

    viterbi_path_array #(.NS(NS), .NCOL(NCOL), .CW(CW), .EPS(EPS)) u0 (
        .clk(clk), .rst_n(rst_n), .start_fwd(start_fwd), .start_bwd(start_bwd),
        .col_valid(col_valid), .local_cost(local_cost), .trans_cost(trans_cost),
        .path_row(path_row), .path_valid(path_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rnd(input int m);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'(lfsr[15:0]) % m;
    endfunction

    // Reference column update (R3, R4, R5).
    function automatic void m_step();
        int nc [NS];
        int best, c, p;
        if (!m_fwd || m_cols >= NCOL) return;
        for (int j = 0; j < NS; j++) begin
            best = m_cost[j] + tr[j][0];
            p = 0;
            if (j > 0) begin
                c = m_cost[j-1] + tr[j][1];
                if (c + EPS < best) begin best = c; p = -1; end
            end
            if (j < NS-1) begin
                c = m_cost[j+1] + tr[j][2];
                if (c + EPS < best) begin best = c; p = 1; end
            end
            nc[j] = (best + loc[j] > CMAX) ? CMAX : best + loc[j];
            m_ptr[m_cols][j] = p;
        end
        for (int j = 0; j < NS; j++) m_cost[j] = nc[j];
        m_cols++;
    endfunction

    // Reference backtrack (R7, R8).
    function automatic void m_back();
        int r;
        exp_n = m_cols;
        r = 0;
        for (int j = 1; j < NS; j++) if (m_cost[j] < m_cost[r]) r = j;
        for (int i = m_cols-1; i >= 0; i--) begin
            exp_rows[m_cols-1-i] = r;
            r += m_ptr[i][r];
        end
        m_cols = 0;
        m_fwd = 0;
    endfunction

    task automatic do_start();
        @(negedge clk); start_fwd = 1'b1;
        @(negedge clk); start_fwd = 1'b0;
        for (int j = 0; j < NS; j++) m_cost[j] = 0;
        m_cols = 0; m_fwd = 1;
    endtask

    task automatic do_col();
        @(negedge clk);
        for (int j = 0; j < NS; j++) begin
            local_cost[j*CW +: CW] = CW'(loc[j]);
            for (int s = 0; s < 3; s++) trans_cost[(3*j+s)*CW +: CW] = CW'(tr[j][s]);
        end
        col_valid = 1'b1;
        @(negedge clk); col_valid = 1'b0;
        m_step();
    endtask

    task automatic set_col(input int l0, input int l1, input int l2, input int l3, input int t);
        loc[0] = l0; loc[1] = l1; loc[2] = l2; loc[3] = l3;
        for (int j = 0; j < NS; j++) for (int s = 0; s < 3; s++) tr[j][s] = t;
    endtask

    // Backtrack and compare; inject = 1 pulses controls mid-pass (R10).
    task automatic run_bwd(input string req, input bit inject);
        int got;
        got = 0;
        m_back();
        @(negedge clk); start_bwd = 1'b1;
        @(negedge clk); start_bwd = 1'b0;
        for (int k = 0; k < NCOL + 4; k++) begin
            @(negedge clk);
            start_fwd = 1'b0; start_bwd = 1'b0; col_valid = 1'b0;
            if (path_valid) begin
                if (got < exp_n) check(int'(path_row) == exp_rows[got], req, int'(path_row), exp_rows[got]);
                got++;
            end
            if (inject && k == 2) begin start_fwd = 1'b1; start_bwd = 1'b1; col_valid = 1'b1; end
        end
        check(got == exp_n, {req, " count"}, got, exp_n);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(path_valid == 1'b0, "R1 reset valid", int'(path_valid), 0);
        set_col(1, 2, 3, 4, 0);
        do_col();   // R1: ignored before any start_fwd
        run_bwd("R10 R1 empty", 1'b0);
    endtask

    task automatic t_diagonal();
        do_start();
        for (int i = 0; i < NCOL; i++) begin
            int t = (i < NS) ? i : NCOL - 1 - i;
            for (int j = 0; j < NS; j++) loc[j] = (j == t) ? 0 : 50;
            for (int j = 0; j < NS; j++) for (int s = 0; s < 3; s++) tr[j][s] = 1;
            do_col();
        end
        run_bwd("R3 R8 diagonal", 1'b0);
    endtask

    task automatic t_ties();
        do_start();
        for (int i = 0; i < 5; i++) begin set_col(5, 5, 5, 5, 0); do_col(); end
        m_back(); m_fwd = 1;   // expected all row 0; recompute via reference below
        do_start();
        for (int i = 0; i < 5; i++) begin set_col(5, 5, 5, 5, 0); do_col(); end
        run_bwd("R4 R7 ties", 1'b0);
    endtask

    task automatic t_eps(input int gap);
        do_start();
        set_col(10, 10 - gap, 100, 100, 0); do_col();
        set_col(0, 100, 100, 100, 0); do_col();
        run_bwd(gap > EPS ? "R4 eps beyond" : "R4 eps within", 1'b0);
        if (gap > EPS) check(exp_rows[1] == 1, "R4 ref down", exp_rows[1], 1);
        else           check(exp_rows[1] == 0, "R4 ref self", exp_rows[1], 0);
    endtask

    task automatic t_edge();
        do_start();
        set_col(0, 40, 40, 0, 0); do_col();
        for (int i = 0; i < 3; i++) begin
            set_col(0, 30, 30, 0, 0);
            tr[0][0] = 200; tr[NS-1][0] = 200;
            do_col();
        end
        run_bwd("R5 edges", 1'b0);
    endtask

    task automatic t_overflow();
        do_start();
        for (int i = 0; i < NCOL + 3; i++) begin
            set_col(rnd(20), rnd(20), rnd(20), rnd(20), 3);
            do_col();
        end
        run_bwd("R6 full stack", 1'b1);
        run_bwd("R10 after pass", 1'b0);
    endtask

    task automatic t_saturate();
        do_start();
        set_col(1000, 900, 1000, 1000, 0); do_col();
        set_col(1000, 1000, 10, 1000, 0); tr[1][0] = 5; do_col();
        run_bwd("R3 saturate", 1'b0);
    endtask

    task automatic t_restart();
        do_start();
        set_col(0, 9, 9, 9, 0); do_col(); do_col();
        do_start();   // R2: earlier columns discarded
        set_col(9, 9, 0, 9, 1); do_col();
        run_bwd("R2 restart", 1'b0);
        do_start();
        set_col(1, 2, 3, 4, 0); do_col();
        @(negedge clk); start_fwd = 1'b1; start_bwd = 1'b1;
        @(negedge clk); start_fwd = 1'b0; start_bwd = 1'b0;
        for (int j = 0; j < NS; j++) m_cost[j] = 0;
        m_cols = 0; m_fwd = 1;
        run_bwd("R11 priority", 1'b0);
    endtask

    task automatic t_random(input int runs);
        for (int r = 0; r < runs; r++) begin
            do_start();
            for (int i = 0; i < NCOL; i++) begin
                for (int j = 0; j < NS; j++) begin
                    loc[j] = rnd(64);
                    for (int s = 0; s < 3; s++) tr[j][s] = rnd(32);
                end
                do_col();
            end
            run_bwd("R3 R8 R9 random", 1'b0);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++; checks++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_fwd = 0; m_cols = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_diagonal();
        t_ties();
        t_eps(EPS);
        t_eps(EPS + 1);
        t_edge();
        t_overflow();
        t_saturate();
        t_restart();
        t_random(12);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule